// File: doc/BRIEF.md
# SPI Master Peripheral with Status Flags

This block is a CPU-facing serial peripheral interface master for one byte at a time. Software sets the clock polarity, the clock phase, the bit order and the clock rate on a set of configuration inputs. Writing the data register starts an 8-bit full-duplex exchange on `sck`/`mosi`/`miso`. Reading the data register returns the last byte that was fully received.

A status register holds two event flags and one control bit. The first flag marks a completed exchange, and the second marks a data write that arrived while a transfer was in flight. The control bit doubles the serial clock rate. Both flags clear through a two-step handshake: read the status register while a flag is set, then access the data register. The completion flag also clears on an interrupt-acknowledge pulse. An interrupt request follows the completion flag when interrupts are enabled.

In master mode, the block watches the slave-select line as an input. When that line is pulled low from outside, the completion flag is raised so software can tell that another master has taken the bus.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, `stat_rdata` reads 0x00, `irq` is 0, `dat_rdata` reads 0x00 and `sck` rests at the `cfg_cpol` level.
- R2: `stat_rdata` bit 7 is the completion flag, bit 6 is the collision flag, bits 5..1 always read 0, and bit 0 is the double-speed bit. A `stat_wr` pulse loads bit 0 from `stat_wbit`.
- R3: A `dat_wr` pulse while `cfg_en`=1 and no transfer is running starts an 8-bit exchange. The completion flag rises 16 half-periods after the write edge, and from that cycle on `dat_rdata` holds the byte received on `miso`.
- R4: `cfg_rate` values 0,1,2,3 select an SCK period of 4, 16, 64 or 128 system clocks. When the double-speed bit is 1 the period is halved (2, 8, 32 or 64). Between transfers `sck` rests at `cfg_cpol`.
- R5: When `cfg_cpha`=0, the first data bit is on `mosi` before the first SCK edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. When `cfg_cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. `cfg_cpol`=1 inverts the SCK level, which makes falling edges the leading ones.
- R6: `cfg_lsb_first`=0 sends and receives bit 7 first. `cfg_lsb_first`=1 sends and receives bit 0 first.
- R7: `irq` is 1 exactly when the completion flag and `cfg_irq_en` are both 1. An `irq_ack` pulse clears the completion flag.
- R8: After a `stat_rd` that finds either flag set, the next `dat_rd` or `dat_wr` clears both flags. A data access without that earlier status read leaves the flags unchanged.
- R9: A `dat_wr` during a transfer sets the collision flag. It changes neither the byte being sent nor the byte being received, nor the timing of the transfer.
- R10: When a flag-setting event and the clearing data access fall in the same cycle, the flag ends up set.
- R11: When `cfg_en`=1 and `cfg_master`=1, a falling edge on `ss_n` (after synchronisation) sets the completion flag. With `cfg_master`=0 that edge has no effect.
- R12: A `dat_wr` while `cfg_en`=0 starts no transfer: `sck` does not toggle and no flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Peripheral enable |
| cfg_master | input | 1 | Master mode; enables slave-select watching |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first on the wire |
| cfg_rate | input | 2 | Base SCK divide select |
| dat_wr | input | 1 | Data register write strobe |
| dat_rd | input | 1 | Data register read strobe |
| dat_wdata | input | 8 | Byte to send |
| dat_rdata | output | 8 | Last received byte |
| stat_wr | input | 1 | Status register write strobe |
| stat_rd | input | 1 | Status register read strobe |
| stat_wbit | input | 1 | Value written into the double-speed bit |
| stat_rdata | output | 8 | Status register contents |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select line, watched as an input |

## Verification
The hard cycle is the one where the clearing data access meets a new flag-setting event. The bench reaches it by reading status while the collision flag is set, then writing the data register again while the transfer is still shifting. The clear and a fresh collision then land on the same edge. Status must afterwards show the collision flag still set with the completion flag clear. The scoreboard then confirms that the transferred bytes and the total duration of the interrupted exchange are unchanged.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int unsigned HALF_MAX = 64;
  localparam int unsigned CNT_W    = $clog2(HALF_MAX);

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_mode_t;

  // System clocks per SCK half-period for a rate code and speed bit.
  function automatic int unsigned half_period(input logic [1:0] rate, input logic dbl);
    int unsigned full;
    full = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    if (dbl) full = full >> 1;
    return full >> 1;
  endfunction

endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == half_m1);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  spi_mode_t         mode_in,
  input  logic [CNT_W-1:0]  half_in,
  input  logic              cpol_live,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  half_m1,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi
);

  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  logic              busy_q, busy_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              phase_q, phase_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  spi_mode_t         mode_q, mode_d;
  logic [CNT_W-1:0]  half_q, half_d;
  logic              mosi_q, mosi_d;

  logic              last_edge, is_sample;
  logic [EDGE_W:0]   nxt_idx;
  logic [DATA_W-1:0] rx_shift;

  function automatic logic pick(input logic [DATA_W-1:0] v, input logic [IDX_W-1:0] i,
                                input logic lsb);
    return lsb ? v[i] : v[IDX_W'(DATA_W - 1) - i];
  endfunction

  always_comb begin
    last_edge = (edge_q == EDGE_W'(EDGES - 1));
    is_sample = (edge_q[0] == mode_q.cpha);
    nxt_idx   = ({1'b0, edge_q} + 1'b1) >> 1;
    rx_shift  = mode_q.lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
    done      = busy_q && tick && last_edge;

    busy_d  = busy_q;
    edge_d  = edge_q;
    phase_d = phase_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    buf_d   = buf_q;
    mode_d  = mode_q;
    half_d  = half_q;
    mosi_d  = mosi_q;

    if (start) begin
      busy_d  = 1'b1;
      edge_d  = '0;
      phase_d = 1'b0;
      tx_d    = wdata;
      mode_d  = mode_in;
      half_d  = half_in;
      if (!mode_in.cpha) mosi_d = pick(wdata, '0, mode_in.lsb_first);
    end else if (busy_q && tick) begin
      phase_d = ~phase_q;
      edge_d  = edge_q + 1'b1;
      if (is_sample) rx_d = rx_shift;
      else if (nxt_idx < (EDGE_W + 1)'(DATA_W))
        mosi_d = pick(tx_q, nxt_idx[IDX_W-1:0], mode_q.lsb_first);
      if (last_edge) begin
        busy_d = 1'b0;
        buf_d  = is_sample ? rx_shift : rx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      buf_q   <= '0;
      mode_q  <= '0;
      half_q  <= '0;
      mosi_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      edge_q  <= edge_d;
      phase_q <= phase_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      buf_q   <= buf_d;
      mode_q  <= mode_d;
      half_q  <= half_d;
      mosi_q  <= mosi_d;
    end
  end

  assign busy    = busy_q;
  assign half_m1 = half_q;
  assign rx_data = buf_q;
  assign mosi    = mosi_q;
  assign sck     = busy_q ? (mode_q.cpol ^ phase_q) : cpol_live;

  // R9: the byte being shifted is not disturbed while a transfer runs
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done |=> $stable(tx_q));

  // R3: the final edge ends the transfer
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  // R4: SCK returns to its resting level at the end of a transfer
  p_sck_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !phase_q);

endmodule

// File: rtl/spi_host_flags.sv
module spi_host_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic busy,
  input  logic dat_wr,
  input  logic dat_rd,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic stat_wbit,
  input  logic irq_ack,
  input  logic irq_en,
  input  logic ss_watch,
  input  logic ss_n,
  output logic spif,
  output logic wcol,
  output logic dbl,
  output logic irq
);

  logic spif_q, spif_d;
  logic wcol_q, wcol_d;
  logic dbl_q, dbl_d;
  logic armed_q, armed_d;
  logic ss_s1_q, ss_s2_q, ss_s3_q;
  logic ss_fall, data_acc, clr, coll;

  always_comb begin
    ss_fall  = ss_watch && ss_s3_q && !ss_s2_q;
    data_acc = dat_wr || dat_rd;
    clr      = armed_q && data_acc;
    coll     = dat_wr && busy;

    spif_d = done || ss_fall || (spif_q && !clr && !irq_ack);
    wcol_d = coll || (wcol_q && !clr);
    dbl_d  = stat_wr ? stat_wbit : dbl_q;

    if (data_acc)     armed_d = 1'b0;
    else if (stat_rd) armed_d = spif_q || wcol_q;
    else              armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      dbl_q   <= 1'b0;
      armed_q <= 1'b0;
      ss_s1_q <= 1'b1;
      ss_s2_q <= 1'b1;
      ss_s3_q <= 1'b1;
    end else begin
      spif_q  <= spif_d;
      wcol_q  <= wcol_d;
      dbl_q   <= dbl_d;
      armed_q <= armed_d;
      ss_s1_q <= ss_n;
      ss_s2_q <= ss_s1_q;
      ss_s3_q <= ss_s2_q;
    end
  end

  assign spif = spif_q;
  assign wcol = wcol_q;
  assign dbl  = dbl_q;
  assign irq  = spif_q && irq_en;

  // R3: completion raises the flag
  p_done_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> spif_q);

  // R9 / R10: a write during a transfer always leaves the collision flag set
  p_coll_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && busy |=> wcol_q);

  // R7: acknowledge clears the completion flag when nothing sets it
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !done && !ss_fall |=> !spif_q);

  // R8: status-read-then-data-access clears both flags
  p_seq_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && (dat_wr || dat_rd) && !done && !ss_fall && !(dat_wr && busy)
    |=> !spif_q && !wcol_q);

  // R11: a watched slave-select fall raises the completion flag
  p_ss_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ss_fall |=> spif_q);

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_master,
  input  logic              cfg_irq_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [1:0]        cfg_rate,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [DATA_W-1:0] dat_rdata,
  input  logic              stat_wr,
  input  logic              stat_rd,
  input  logic              stat_wbit,
  output logic [7:0]        stat_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ss_n
);

  logic             rst_s1_q, rst_s2_q, rst_int_n;
  logic             busy, done, tick, start;
  logic             spif, wcol, dbl;
  logic [CNT_W-1:0] half_in, half_m1;
  spi_mode_t        mode_in;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  always_comb begin
    start             = dat_wr && cfg_en && !busy;
    half_in           = CNT_W'(half_period(cfg_rate, dbl) - 1);
    mode_in.cpol      = cfg_cpol;
    mode_in.cpha      = cfg_cpha;
    mode_in.lsb_first = cfg_lsb_first;
  end

  spi_host_clkgen u_clkgen (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (busy),
    .half_m1 (half_m1),
    .tick    (tick)
  );

  spi_host_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .wdata     (dat_wdata),
    .mode_in   (mode_in),
    .half_in   (half_in),
    .cpol_live (cfg_cpol),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy),
    .done      (done),
    .half_m1   (half_m1),
    .rx_data   (dat_rdata),
    .sck       (sck),
    .mosi      (mosi)
  );

  spi_host_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .done      (done),
    .busy      (busy),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .stat_rd   (stat_rd),
    .stat_wr   (stat_wr),
    .stat_wbit (stat_wbit),
    .irq_ack   (irq_ack),
    .irq_en    (cfg_irq_en),
    .ss_watch  (cfg_en && cfg_master),
    .ss_n      (ss_n),
    .spif      (spif),
    .wcol      (wcol),
    .dbl       (dbl),
    .irq       (irq)
  );

  assign stat_rdata = {spif, wcol, 5'b00000, dbl};

  // R3 / R12: an enabled write when idle starts a transfer
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    dat_wr && cfg_en && !busy |=> busy);

  // R12: a disabled block never begins shifting
  p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy && !(dat_wr && cfg_en) |=> !busy);

endmodule

// File: tb/spi_host_regs_tb.sv
module spi_host_regs_tb_top;

  localparam int CLK_P = 10;

  logic       clk, rst_n;
  logic       cfg_en, cfg_master, cfg_irq_en, cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [1:0] cfg_rate;
  logic       dat_wr, dat_rd, stat_wr, stat_rd, stat_wbit, irq_ack;
  logic [7:0] dat_wdata, dat_rdata, stat_rdata;
  logic       irq, sck, mosi, miso, ss_n;

  spi_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_irq_en(cfg_irq_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_rate(cfg_rate), .dat_wr(dat_wr),
    .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .stat_wr(stat_wr), .stat_rd(stat_rd), .stat_wbit(stat_wbit),
    .stat_rdata(stat_rdata), .irq_ack(irq_ack), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int mon_cnt = 0;
  int sck_toggles = 0;
  logic dbl_b = 1'b0;

  typedef struct {
    logic [7:0] tx;
    logic [7:0] rx;
    int         div;
    longint     t_wr;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  // slave model state
  event       sl_go;
  logic [7:0] sl_tx, sl_cap;
  logic       sl_cpha, sl_lsb;
  int         sl_period;

  always @(sck) sck_toggles++;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int exp_div(input logic [1:0] rate, input logic dbl);
    int d;
    d = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    return dbl ? d / 2 : d;
  endfunction

  // slave device: drives miso, captures mosi, measures the SCK period
  initial begin
    longint t0;
    miso = 1'b0;
    forever begin
      @(sl_go);
      sl_cap    = 8'h00;
      sl_period = 0;
      t0        = 0;
      if (!sl_cpha) miso = sl_lsb ? sl_tx[0] : sl_tx[7];
      for (int k = 0; k < 16; k++) begin
        @(sck);
        if (k == 0) t0 = $time;
        if (k == 2) sl_period = int'(($time - t0) / CLK_P);
        if (((k % 2) == 0) == (sl_cpha == 1'b0)) begin
          if (sl_lsb) sl_cap[k / 2] = mosi;
          else        sl_cap[7 - k / 2] = mosi;
        end else if ((k + 1) / 2 < 8) begin
          miso = sl_lsb ? sl_tx[(k + 1) / 2] : sl_tx[7 - (k + 1) / 2];
        end
      end
    end
  end

  // monitor: pops an expected item on each rise of the completion flag
  initial begin
    logic prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && stat_rdata[7] && !prev && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk("R3", {e.tag, " received byte"}, {24'h0, dat_rdata}, {24'h0, e.rx});
        chk("R5/R6", {e.tag, " byte on mosi"}, {24'h0, sl_cap}, {24'h0, e.tx});
        chk("R4", {e.tag, " sck period"}, sl_period, e.div);
        chk("R3", {e.tag, " duration"}, int'(($time - e.t_wr) / CLK_P), 8 * e.div);
        chk("R4", {e.tag, " sck rest level"}, {31'h0, sck}, {31'h0, cfg_cpol});
        mon_cnt++;
      end
      prev = stat_rdata[7];
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stat_write(input logic b);
    stat_wr = 1'b1; stat_wbit = b;
    @(negedge clk);
    stat_wr = 1'b0;
    dbl_b = b;
  endtask

  task automatic stat_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic data_read();
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] v);
    dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic lsb,
                          input logic [1:0] rate, input logic dbl);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_rate = rate;
    stat_write(dbl);
    cyc(2);
  endtask

  // driver: pushes the expected item, arms the slave, writes the byte
  task automatic xfer(input logic [7:0] tx, input logic [7:0] stx, input string tag);
    exp_t e;
    e.tx  = tx;
    e.rx  = stx;
    e.div = exp_div(cfg_rate, dbl_b);
    e.tag = tag;
    sl_tx = stx; sl_cpha = cfg_cpha; sl_lsb = cfg_lsb_first;
    ->sl_go;
    dat_wr = 1'b1; dat_wdata = tx;
    @(negedge clk);
    dat_wr = 1'b0;
    e.t_wr = $time;
    exp_q.push_back(e);
  endtask

  task automatic wait_done(input string req);
    int m0;
    m0 = mon_cnt;
    for (int i = 0; i < 5000 && mon_cnt == m0; i++) @(negedge clk);
    chk(req, "transfer completed", {31'h0, mon_cnt != m0}, 32'h1);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // watchdog
  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int t0;
    rst_n = 1'b0;
    cfg_en = 1'b1; cfg_master = 1'b1; cfg_irq_en = 1'b0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_rate = 2'd0;
    dat_wr = 1'b0; dat_rd = 1'b0; dat_wdata = 8'h00;
    stat_wr = 1'b0; stat_rd = 1'b0; stat_wbit = 1'b0; irq_ack = 1'b0;
    ss_n = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    chk("R1", "status after reset", {24'h0, stat_rdata}, 32'h00);
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
    chk("R1", "rx buffer after reset", {24'h0, dat_rdata}, 32'h00);
    chk("R1", "sck rest level", {31'h0, sck}, 32'h0);

    // R2 status layout: only bit 0 is writable
    stat_write(1'b1);
    chk("R2", "status after speed bit write", {24'h0, stat_rdata}, 32'h01);

    // transfers across modes, orders and rates
    set_mode(1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
    stat_read(); xfer(8'hA5, 8'h3C, "R5 mode0 msb div2"); wait_done("R3");
    set_mode(1'b0, 1'b1, 1'b1, 2'd0, 1'b0);
    stat_read(); xfer(8'h96, 8'h71, "R5 mode1 R6 lsb div4"); wait_done("R3");
    set_mode(1'b1, 1'b0, 1'b0, 2'd1, 1'b1);
    stat_read(); xfer(8'h5A, 8'hE1, "R5 mode2 msb div8"); wait_done("R3");
    set_mode(1'b1, 1'b1, 1'b1, 2'd3, 1'b0);
    stat_read(); xfer(8'h81, 8'h18, "R5 mode3 R6 lsb div128"); wait_done("R3");
    set_mode(1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    stat_read(); xfer(8'h0F, 8'hF0, "R6 mode0 lsb div64"); wait_done("R3");

    // R8: data access alone does not clear; the full sequence does
    data_read();
    chk("R8", "flag kept without status read", {24'h0, stat_rdata}, 32'h80);
    stat_read(); data_read();
    chk("R8", "flag cleared by sequence", {24'h0, stat_rdata}, 32'h00);

    // R7 interrupt request and acknowledge
    cfg_irq_en = 1'b1;
    set_mode(1'b0, 1'b1, 1'b0, 2'd0, 1'b1);
    stat_read(); xfer(8'h3E, 8'hC7, "R7 mode1 msb div2"); wait_done("R7");
    chk("R7", "irq with flag and enable", {31'h0, irq}, 32'h1);
    cfg_irq_en = 1'b0; @(negedge clk);
    chk("R7", "irq masked by enable", {31'h0, irq}, 32'h0);
    cfg_irq_en = 1'b1;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R7", "irq after acknowledge", {31'h0, irq}, 32'h0);
    chk("R7", "status after acknowledge", {24'h0, stat_rdata}, 32'h01);
    cfg_irq_en = 1'b0;

    // R9 / R10 collision during a transfer, clear coinciding with a new collision
    set_mode(1'b0, 1'b0, 1'b0, 2'd1, 1'b1);
    stat_read(); xfer(8'hC3, 8'h5C, "R9 collided transfer");
    cyc(10);
    data_write(8'hFF);
    chk("R9", "collision flag set", {24'h0, stat_rdata}, 32'h41);
    stat_read();
    cyc(2);
    data_write(8'h00);
    chk("R10", "collision kept over same-cycle clear", {24'h0, stat_rdata}, 32'h41);
    wait_done("R9");
    chk("R9", "both flags after completion", {24'h0, stat_rdata}, 32'hC1);
    stat_read(); data_read();
    chk("R8", "both flags cleared by sequence", {24'h0, stat_rdata}, 32'h01);

    // R11 slave-select watching
    ss_n = 1'b0; cyc(6);
    chk("R11", "flag on select low in master mode", {24'h0, stat_rdata}, 32'h81);
    ss_n = 1'b1; cyc(4);
    stat_read(); data_read();
    cfg_master = 1'b0;
    ss_n = 1'b0; cyc(6);
    chk("R11", "no flag outside master mode", {24'h0, stat_rdata}, 32'h01);
    ss_n = 1'b1; cyc(4);
    cfg_master = 1'b1;

    // R12 disabled block ignores data writes
    cfg_en = 1'b0;
    t0 = sck_toggles;
    data_write(8'h55);
    cyc(40);
    chk("R12", "sck toggles while disabled", sck_toggles - t0, 0);
    chk("R12", "status while disabled", {24'h0, stat_rdata}, 32'h01);
    cfg_en = 1'b1;

    chk("R3", "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule